// File: doc/BRIEF.md
# System Interrupt Mask and Level Router

This block is the system-wide front end of an interrupt controller. It samples up to 32 device interrupt lines into a pending register, holds a disable mask beside it, and turns every pending bit that is not disabled into a processor interrupt level. Each source bit has a level assigned through a per-bit table. The resulting 16-bit level vector is presented together with the index of the one processor that software has chosen to receive device interrupts. A separate per-processor block merges this vector with that processor's own sources.

Software reaches the block through a simple write strobe, a 3-bit word select (byte address bits [4:2]), write data and combinational read data. Two words read back the state: the pending bits and the disable mask. One word enables sources by clearing mask bits. One word disables sources, and also drops their pending bits. One word picks the target processor. Only a fixed set of mask bits can be changed by software. The top mask bit is a global switch that silences every device level at once.

Top module: `sys_irq_router`

## Requirements
- R1: After reset the pending bits are zero, the mask reads 0x4FB2007F, the target index is 0 and the level vector is zero.
- R2: Read data is combinational on the word select. Word 1 returns the mask. Words 2 to 7 return zero.
- R3: Write data to words 2 and 3 is ANDed with 0xB04DFF80 before use, so mask bits outside that pattern keep their reset value forever.
- R4: A write to word 2 clears the written, writable mask bits from the next cycle on.
- R5: A write to word 3 sets the written, writable mask bits and forces those pending bits to zero in the next cycle.
- R6: A write to word 4 loads the target index with the write data modulo NUM_CPU (its low bits).
- R7: The pending register takes the value of the device inputs one clock later; word 0 returns it with bit 31 forced to zero.
- R8: Level vector bit L is set when some bit j is pending and not masked and LEVEL_TABLE[j] equals L. The default table gives bit j the level (j mod 15)+1.
- R9: While mask bit 31 is set, the level vector is zero whatever is pending.
- R10: Writes to words 0, 1, 5, 6 and 7 change neither the mask, the pending bits nor the target index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | 32 | Level-sensitive device interrupt lines |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_word | input | 3 | Word select (byte address bits [4:2]) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word |
| lvl_vec | output | 16 | Processor interrupt levels requested by devices |
| tgt_cpu | output | CPU_W | Index of the processor that receives lvl_vec |

## Verification
Directed cases first enable every writable source with all inputs high. This shows whether the level table folds bits that share a level and whether locked bits stay masked. The global-disable bit is then set and cleared while inputs stay high. This tells global gating apart from the clearing of pending bits that a disable write causes. Target writes with values above the processor count show whether the index wraps. Random device patterns mixed with random writes to all eight words then compare the level vector, target and read data against a bench model each cycle. Writes to unused words are told apart from real ones by the read-back of mask and pending bits.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int SRC_N  = 32;
    localparam int LVL_W  = 4;
    localparam int LVL_N  = 1 << LVL_W;

    // Mask bits software may change; the rest stay at their reset value.
    localparam logic [SRC_N-1:0] SW_WRITABLE = 32'hB04D_FF80;
    localparam logic [SRC_N-1:0] MASK_AT_RST = ~SW_WRITABLE;
    localparam int               GLOBAL_OFF  = 31;

    typedef enum logic [2:0] {
        WD_PEND   = 3'd0,
        WD_MASK   = 3'd1,
        WD_ENABLE = 3'd2,
        WD_DISABLE= 3'd3,
        WD_TARGET = 3'd4
    } word_e;

    typedef logic [SRC_N-1:0][LVL_W-1:0] lvl_tab_t;

    function automatic lvl_tab_t default_levels();
        lvl_tab_t t;
        for (int j = 0; j < SRC_N; j++) begin
            t[j] = LVL_W'((j % (LVL_N - 1)) + 1);
        end
        return t;
    endfunction

endpackage

// File: rtl/sirq_regs.sv
module sirq_regs
    import sirq_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] dev_irq,
    input  logic             bus_wr,
    input  logic [2:0]       bus_word,
    input  logic [31:0]      bus_wdata,
    output logic [SRC_N-1:0] pend_q,
    output logic [SRC_N-1:0] mask_q,
    output logic [CPU_W-1:0] tgt_q,
    output logic [31:0]      rdata
);

    logic [SRC_N-1:0] en_bits;
    logic [SRC_N-1:0] dis_bits;
    logic             tgt_load;

    // Write decode: filtered bit sets for the two mask words.
    always_comb begin
        en_bits  = '0;
        dis_bits = '0;
        tgt_load = 1'b0;
        if (bus_wr) begin
            unique case (bus_word)
                WD_ENABLE:  en_bits  = bus_wdata & SW_WRITABLE;
                WD_DISABLE: dis_bits = bus_wdata & SW_WRITABLE;
                WD_TARGET:  tgt_load = 1'b1;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= MASK_AT_RST;
            tgt_q  <= '0;
        end else begin
            pend_q <= dev_irq & ~dis_bits;
            mask_q <= (mask_q & ~en_bits) | dis_bits;
            if (tgt_load) begin
                tgt_q <= bus_wdata[CPU_W-1:0];
            end
        end
    end

    // Read mux.
    always_comb begin
        unique case (bus_word)
            WD_PEND: begin
                rdata             = pend_q;
                rdata[GLOBAL_OFF] = 1'b0;
            end
            WD_MASK: rdata = mask_q;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/sirq_level_map.sv
module sirq_level_map
    import sirq_pkg::*;
#(
    parameter lvl_tab_t LEVEL_TABLE = default_levels()
) (
    input  logic [SRC_N-1:0] pend_q,
    input  logic [SRC_N-1:0] mask_q,
    output logic [LVL_N-1:0] lvl_vec
);

    logic [SRC_N-1:0] active;
    logic [LVL_N-1:0] lvl_raw;

    assign active = pend_q & ~mask_q;

    for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int j = 0; j < SRC_N; j++) begin
                if (LEVEL_TABLE[j] == LVL_W'(l)) begin
                    hit = hit | active[j];
                end
            end
        end
        assign lvl_raw[l] = hit;
    end

    assign lvl_vec = mask_q[GLOBAL_OFF] ? '0 : lvl_raw;

endmodule

// File: rtl/sys_irq_router.sv
module sys_irq_router
    import sirq_pkg::*;
#(
    parameter int       NUM_CPU     = 4,
    parameter lvl_tab_t LEVEL_TABLE = default_levels(),
    localparam int      CPU_W       = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      dev_irq,
    input  logic             bus_wr,
    input  logic [2:0]       bus_word,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic [15:0]      lvl_vec,
    output logic [CPU_W-1:0] tgt_cpu
);

    logic [SRC_N-1:0] pend_q;
    logic [SRC_N-1:0] mask_q;

    sirq_regs #(
        .NUM_CPU (NUM_CPU),
        .CPU_W   (CPU_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_irq   (dev_irq),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .pend_q    (pend_q),
        .mask_q    (mask_q),
        .tgt_q     (tgt_cpu),
        .rdata     (bus_rdata)
    );

    sirq_level_map #(
        .LEVEL_TABLE (LEVEL_TABLE)
    ) u_map (
        .pend_q  (pend_q),
        .mask_q  (mask_q),
        .lvl_vec (lvl_vec)
    );

endmodule

// File: rtl/sys_irq_router_chk.sv
module sys_irq_router_chk
    import sirq_pkg::*;
#(
    parameter int CPU_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      dev_irq,
    input logic             bus_wr,
    input logic [2:0]       bus_word,
    input logic [31:0]      bus_wdata,
    input logic [15:0]      lvl_vec,
    input logic [CPU_W-1:0] tgt_cpu,
    input logic [31:0]      pend_q,
    input logic [31:0]      mask_q
);

    assert_locked_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mask_q & ~SW_WRITABLE) == MASK_AT_RST));

    assert_enable_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == 3'd2) |=> ((mask_q & $past(bus_wdata & SW_WRITABLE)) == '0));

    assert_disable_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == 3'd3) |=>
            (((mask_q & $past(bus_wdata & SW_WRITABLE)) == $past(bus_wdata & SW_WRITABLE)) &&
             ((pend_q & $past(bus_wdata & SW_WRITABLE)) == '0)));

    assert_target_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == 3'd4) |=> (tgt_cpu == $past(bus_wdata[CPU_W-1:0])));

    assert_pend_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_word == 3'd3) |=> (pend_q == $past(dev_irq)));

    assert_global_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[GLOBAL_OFF] |-> (lvl_vec == '0));

    assert_unused_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_word <= 3'd1 || bus_word >= 3'd5)) |=>
            ($stable(mask_q) && $stable(tgt_cpu)));

endmodule

bind sys_irq_router sys_irq_router_chk #(.CPU_W(CPU_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_irq   (dev_irq),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .lvl_vec   (lvl_vec),
    .tgt_cpu   (tgt_cpu),
    .pend_q    (pend_q),
    .mask_q    (mask_q)
);

// File: tb/sys_irq_router_tb.sv
module sys_irq_router_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCPU       = 4;
    localparam int CW         = 2;
    localparam logic [31:0] WRM = 32'hB04D_FF80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dev_irq = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] lvl_vec;
    logic [CW-1:0] tgt_cpu;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0]   pend_m;
    logic [31:0]   mask_m;
    logic [CW-1:0] tgt_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    sys_irq_router #(.NUM_CPU(NCPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lvl_vec(lvl_vec), .tgt_cpu(tgt_cpu)
    );

    function automatic logic [15:0] exp_lvl(logic [31:0] p, logic [31:0] m);
        logic [15:0] v = '0;
        if (m[31]) return '0;
        for (int j = 0; j < 32; j++) begin
            if (p[j] && !m[j]) v[(j % 15) + 1] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_rd(logic [2:0] w);
        if (w == 3'd0) return pend_m & 32'h7FFF_FFFF;
        if (w == 3'd1) return mask_m;
        return '0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic step(logic [31:0] dev, logic wr, logic [2:0] w, logic [31:0] d, string tag);
        logic [31:0] setb, clrb;
        dev_irq = dev; bus_wr = wr; bus_word = w; bus_wdata = d;
        @(posedge clk);
        setb = (wr && w == 3'd3) ? (d & WRM) : '0;
        clrb = (wr && w == 3'd2) ? (d & WRM) : '0;
        pend_m = dev & ~setb;
        mask_m = (mask_m & ~clrb) | setb;
        if (wr && w == 3'd4) tgt_m = d[CW-1:0];
        @(negedge clk);
        bus_wr = 1'b0;
        check(mask_m[31] ? "R9 level" : "R8 level", 32'(lvl_vec), 32'(exp_lvl(pend_m, mask_m)));
        check("R6 target", 32'(tgt_cpu), 32'(tgt_m));
        check(tag, bus_rdata, exp_rd(w));
    endtask

    task automatic peek(logic [2:0] w, string tag);
        bus_word = w;
        #1;
        check(tag, bus_rdata, exp_rd(w));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        pend_m = '0; mask_m = 32'h4FB2_007F; tgt_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 level", 32'(lvl_vec), 32'h0);
        check("R1 target", 32'(tgt_cpu), 32'h0);
        peek(3'd0, "R1 pending");
        peek(3'd1, "R1 mask");

        // R3/R4 enable everything writable
        step('1, 1'b1, 3'd2, 32'hFFFF_FFFF, "R4 enable read-back");
        peek(3'd1, "R3 locked bits");
        step('1, 1'b0, 3'd0, 32'h0, "R7 pending bit31 hidden");
        // R9 global off with inputs high; R5 clears pending bit 31
        step('1, 1'b1, 3'd3, 32'h8000_0000, "R5 disable read-back");
        peek(3'd1, "R5 mask");
        step('1, 1'b0, 3'd1, 32'h0, "R9 mask stays");
        step('1, 1'b1, 3'd2, 32'h8000_0000, "R4 global back on");
        // R6 wrap
        step(32'h0000_8000, 1'b1, 3'd4, 32'h7, "R2 target word reads zero");
        step(32'h0000_8000, 1'b1, 3'd4, 32'h5, "R2 target word reads zero");
        // R10 unused words
        step(32'h0040_0000, 1'b1, 3'd6, 32'hFFFF_FFFF, "R10 unused write");
        peek(3'd1, "R10 mask untouched");
        step(32'h0040_0000, 1'b1, 3'd1, 32'hFFFF_FFFF, "R10 mask word write");
        // R8 single source folding
        step(32'h0000_0080, 1'b0, 3'd0, 32'h0, "R8 single source");

        for (int i = 0; i < 600; i++) begin
            logic [2:0]  w  = 3'($urandom_range(0, 7));
            logic        wr = ($urandom_range(0, 2) != 0);
            logic [31:0] d  = $urandom;
            logic [31:0] dv = $urandom & $urandom;
            string tg;
            if (!wr)            tg = "R7 read";
            else if (w == 3'd2) tg = "R4 read";
            else if (w == 3'd3) tg = "R5 read";
            else if (w == 3'd4) tg = "R2 read";
            else                tg = "R10 read";
            step(dv, wr, w, d, tg);
            peek(3'd0, "R7 pending");
            peek(3'd1, "R3 mask");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule